// File: doc/BRIEF.md
# Debug Claim Tag Register with Access Checking

This block holds a small set of claim tag bits that a debugger and the software under debug use to agree on who owns a debug resource. Software reaches the bits through two system-register views of the same storage: a set view, where writing a 1 to a bit sets it, and a clear view, where writing a 1 clears it. Either view reads back the present tag state in the low bits of a 64-bit word. Every bit above the tags reads as zero, and writes to those bits are dropped.

Each access is presented with its decoded register encoding, its direction and its write data. The access is also presented with the privilege context: the current exception level, whether the 64-bit execution feature, EL2 and EL3 are present or enabled, the debug trap controls at EL2 and EL3, and the fine-grained trap controls. A checker resolves each access in the same cycle into one outcome: complete, undefined, trap to EL2 or trap to EL3. A trap also reports its exception class. Only a completed access touches the tags or returns read data. Exception entry and the external debug port are handled elsewhere.

Top module: `dbg_claim_reg`

## Requirements
- R1: After reset every claim bit is 0.
- R2: A completed read through either view returns the claim bits in acc_rdata[7:0], with bit n holding claim bit n. acc_rdata[63:8] is always 0.
- R3: A completed write through the clear view (encoding op0=2, op1=0, CRn=7, CRm=9, op2=6, packed as {op0,op1,CRn,CRm,op2} = 16'h83CE) clears every claim bit whose acc_wdata bit is 1 and leaves the others unchanged. acc_wdata[63:8] has no effect.
- R4: A completed write through the set view (CRm=8, otherwise the same fields, 16'h83C6) sets every claim bit whose acc_wdata bit is 1 and leaves the others unchanged.
- R5: An access at EL0 (cur_el=0), or an access while has_a64 is 0, is undefined. acc_resp encodes 0=complete, 1=undefined, 2=trap to EL2, 3=trap to EL3.
- R6: At EL1 the checks are applied in this strict order. First, undefined when has_el3, el3_undef_prio and el3_dbg_trap are all set. Second, trap to EL2 on a fine-grained hit. Third, trap to EL2 when el2_enabled is set and el2_dbg_route or el2_dbg_trap is set. Fourth, when has_el3 and el3_dbg_trap are set, undefined if el3_sdd_undef is set and trap to EL3 otherwise. Otherwise the access completes.
- R7: A fine-grained hit needs el2_enabled, fgt_impl, and either no EL3 or el3_fgt_enable. It also needs fgt_rd_claim for a read, or fgt_wr_claim for a write.
- R8: At EL2 only the first and fourth EL1 checks apply, in that order. At EL3 (with has_a64) every access completes.
- R9: A trap outcome drives acc_ec to 6'h18. Every other outcome drives acc_ec to 0.
- R10: An access that does not complete leaves the claim bits unchanged and drives acc_rdata to 0.
- R11: An access whose encoding matches neither view, or with acc_valid low, gives acc_hit=0, acc_resp=0, acc_ec=0 and acc_rdata=0, and leaves the claim bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_enc | input | 16 | Register encoding {op0,op1,CRn,CRm,op2} |
| acc_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current exception level |
| has_a64 | input | 1 | 64-bit execution feature present |
| el2_enabled | input | 1 | EL2 enabled in the current state |
| has_el3 | input | 1 | EL3 implemented |
| el3_undef_prio | input | 1 | EL3 undefined-priority mode active |
| el3_sdd_undef | input | 1 | EL3 undefined mode active for debug traps |
| el3_dbg_trap | input | 1 | EL3 debug access trap control |
| el2_dbg_route | input | 1 | EL2 debug routing control |
| el2_dbg_trap | input | 1 | EL2 debug access trap control |
| fgt_impl | input | 1 | Fine-grained trapping implemented |
| el3_fgt_enable | input | 1 | EL3 permits fine-grained traps |
| fgt_rd_claim | input | 1 | Fine-grained read trap for the claim registers |
| fgt_wr_claim | input | 1 | Fine-grained write trap for the claim registers |
| acc_hit | output | 1 | Access targets one of the two views |
| acc_resp | output | 2 | Outcome: 0 complete, 1 undefined, 2 trap EL2, 3 trap EL3 |
| acc_ec | output | 6 | Exception class for traps |
| acc_rdata | output | 64 | Read data |
| claim_state | output | 8 | Present claim bits |

## Verification
The bench builds the block with its defaults: eight tags, a 64-bit access word and the fine-grained trap path generated in. Building it this way puts the second rung of the EL1 ladder within reach, together with the split between the read and write trap bits. It also means that write data set above bit 7 checks the upper-bit masking. Random privilege contexts are biased so that each rung of the priority order, and the rung below each one, is hit many times. Directed cases pin the set and clear semantics, the EL0 and missing-feature cases, and unmatched encodings.

// File: rtl/dbg_claim_pkg.sv
package dbg_claim_pkg;
   localparam int ENC_W = 16;

   typedef enum logic [1:0] {
      ACC_DONE     = 2'd0,
      ACC_UNDEF    = 2'd1,
      ACC_TRAP_EL2 = 2'd2,
      ACC_TRAP_EL3 = 2'd3
   } acc_resp_e;

   localparam logic [ENC_W-1:0] ENC_CLR_VIEW = {2'b10, 3'b000, 4'b0111, 4'b1001, 3'b110};
   localparam logic [ENC_W-1:0] ENC_SET_VIEW = {2'b10, 3'b000, 4'b0111, 4'b1000, 3'b110};
   localparam logic [5:0]       EC_DBG_SYS   = 6'h18;
endpackage

// File: rtl/dbg_claim_access_chk.sv
module dbg_claim_access_chk
   import dbg_claim_pkg::*;
#(
   parameter bit FGT_PRESENT = 1'b1
) (
   input  logic       is_write,
   input  logic [1:0] cur_el,
   input  logic       has_a64,
   input  logic       el2_enabled,
   input  logic       has_el3,
   input  logic       el3_undef_prio,
   input  logic       el3_sdd_undef,
   input  logic       el3_dbg_trap,
   input  logic       el2_dbg_route,
   input  logic       el2_dbg_trap,
   input  logic       fgt_impl,
   input  logic       el3_fgt_enable,
   input  logic       fgt_rd_claim,
   input  logic       fgt_wr_claim,
   output acc_resp_e  resp
);
   logic fgt_hit;
   logic el3_early_undef;
   logic el3_trap_set;
   logic el2_coarse;

   generate
      if (FGT_PRESENT) begin : g_fgt
         logic fgt_allowed;
         assign fgt_allowed = fgt_impl && (!has_el3 || el3_fgt_enable);
         assign fgt_hit     = el2_enabled && fgt_allowed &&
                              (is_write ? fgt_wr_claim : fgt_rd_claim);
      end else begin : g_no_fgt
         logic unused_fgt;
         assign unused_fgt = ^{fgt_impl, el3_fgt_enable, fgt_rd_claim, fgt_wr_claim};
         assign fgt_hit    = 1'b0;
      end
   endgenerate

   assign el3_trap_set    = has_el3 && el3_dbg_trap;
   assign el3_early_undef = el3_trap_set && el3_undef_prio;
   assign el2_coarse      = el2_enabled && (el2_dbg_route || el2_dbg_trap);

   always_comb begin
      resp = ACC_DONE;
      if (!has_a64 || cur_el == 2'd0) begin
         resp = ACC_UNDEF;
      end else if (cur_el != 2'd3) begin
         if (el3_early_undef)
            resp = ACC_UNDEF;
         else if (cur_el == 2'd1 && fgt_hit)
            resp = ACC_TRAP_EL2;
         else if (cur_el == 2'd1 && el2_coarse)
            resp = ACC_TRAP_EL2;
         else if (el3_trap_set)
            resp = el3_sdd_undef ? ACC_UNDEF : ACC_TRAP_EL3;
      end
   end
endmodule

// File: rtl/dbg_claim_store.sv
module dbg_claim_store #(
   parameter int NUM_TAGS = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                set_we,
   input  logic                clr_we,
   input  logic [NUM_TAGS-1:0] wbits,
   output logic [NUM_TAGS-1:0] tags_q
);
   generate
      for (genvar g = 0; g < NUM_TAGS; g++) begin : g_tag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               tags_q[g] <= 1'b0;
            else if (clr_we && wbits[g])
               tags_q[g] <= 1'b0;
            else if (set_we && wbits[g])
               tags_q[g] <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/dbg_claim_reg.sv
module dbg_claim_reg
   import dbg_claim_pkg::*;
#(
   parameter int               NUM_TAGS    = 8,
   parameter int               DATA_W      = 64,
   parameter bit               FGT_PRESENT = 1'b1,
   parameter logic [ENC_W-1:0] CLR_ENC     = ENC_CLR_VIEW,
   parameter logic [ENC_W-1:0] SET_ENC     = ENC_SET_VIEW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic                acc_write,
   input  logic [ENC_W-1:0]    acc_enc,
   input  logic [DATA_W-1:0]   acc_wdata,
   input  logic [1:0]          cur_el,
   input  logic                has_a64,
   input  logic                el2_enabled,
   input  logic                has_el3,
   input  logic                el3_undef_prio,
   input  logic                el3_sdd_undef,
   input  logic                el3_dbg_trap,
   input  logic                el2_dbg_route,
   input  logic                el2_dbg_trap,
   input  logic                fgt_impl,
   input  logic                el3_fgt_enable,
   input  logic                fgt_rd_claim,
   input  logic                fgt_wr_claim,
   output logic                acc_hit,
   output logic [1:0]          acc_resp,
   output logic [5:0]          acc_ec,
   output logic [DATA_W-1:0]   acc_rdata,
   output logic [NUM_TAGS-1:0] claim_state
);
   localparam int PAD_W = DATA_W - NUM_TAGS;

   initial begin
      if (NUM_TAGS < 1 || NUM_TAGS >= DATA_W)
         $error("NUM_TAGS must lie between 1 and DATA_W-1");
      if (CLR_ENC == SET_ENC)
         $error("set and clear views need distinct encodings");
   end

   logic      hit_clr, hit_set, done;
   acc_resp_e chk_resp;
   logic [NUM_TAGS-1:0] tags_q;

   assign hit_clr = acc_valid && (acc_enc == CLR_ENC);
   assign hit_set = acc_valid && (acc_enc == SET_ENC);
   assign acc_hit = hit_clr || hit_set;

   dbg_claim_access_chk #(.FGT_PRESENT(FGT_PRESENT)) u_chk (
      .is_write       (acc_write),
      .cur_el         (cur_el),
      .has_a64        (has_a64),
      .el2_enabled    (el2_enabled),
      .has_el3        (has_el3),
      .el3_undef_prio (el3_undef_prio),
      .el3_sdd_undef  (el3_sdd_undef),
      .el3_dbg_trap   (el3_dbg_trap),
      .el2_dbg_route  (el2_dbg_route),
      .el2_dbg_trap   (el2_dbg_trap),
      .fgt_impl       (fgt_impl),
      .el3_fgt_enable (el3_fgt_enable),
      .fgt_rd_claim   (fgt_rd_claim),
      .fgt_wr_claim   (fgt_wr_claim),
      .resp           (chk_resp)
   );

   assign done = acc_hit && (chk_resp == ACC_DONE);

   dbg_claim_store #(.NUM_TAGS(NUM_TAGS)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (done && acc_write && hit_set),
      .clr_we (done && acc_write && hit_clr),
      .wbits  (acc_wdata[NUM_TAGS-1:0]),
      .tags_q (tags_q)
   );

   logic unused_hi;
   assign unused_hi = ^acc_wdata[DATA_W-1:NUM_TAGS];

   always_comb begin
      acc_resp  = acc_hit ? chk_resp : ACC_DONE;
      acc_ec    = (acc_hit && (chk_resp == ACC_TRAP_EL2 || chk_resp == ACC_TRAP_EL3))
                  ? EC_DBG_SYS : 6'd0;
      acc_rdata = (done && !acc_write) ? {{PAD_W{1'b0}}, tags_q} : '0;
   end

   assign claim_state = tags_q;
endmodule

// File: rtl/dbg_claim_sva.sv
module dbg_claim_sva #(
   parameter int NUM_TAGS = 8,
   parameter int DATA_W   = 64
) (
   input logic                clk,
   input logic                rst_n,
   input logic                acc_hit,
   input logic                acc_write,
   input logic [15:0]         acc_enc,
   input logic [DATA_W-1:0]   acc_wdata,
   input logic [1:0]          cur_el,
   input logic                has_a64,
   input logic [1:0]          acc_resp,
   input logic [5:0]          acc_ec,
   input logic [DATA_W-1:0]   acc_rdata,
   input logic [NUM_TAGS-1:0] claim_state
);
   AST_UPPER_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      acc_rdata[DATA_W-1:NUM_TAGS] == '0); // R2
   AST_CLR_VIEW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && acc_write && acc_resp == 2'd0 && acc_enc == 16'h83CE)
      |=> (claim_state & $past(acc_wdata[NUM_TAGS-1:0])) == '0); // R3
   AST_SET_VIEW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && acc_write && acc_resp == 2'd0 && acc_enc == 16'h83C6)
      |=> (claim_state & $past(acc_wdata[NUM_TAGS-1:0])) == $past(acc_wdata[NUM_TAGS-1:0])); // R4
   AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && (cur_el == 2'd0 || !has_a64)) |-> acc_resp == 2'd1); // R5
   AST_EL3_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_hit && cur_el == 2'd3 && has_a64) |-> acc_resp == 2'd0); // R8
   AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_resp[1] |-> acc_ec == 6'h18) and (!acc_resp[1] |-> acc_ec == 6'd0)); // R9
   AST_FAIL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_resp != 2'd0) |-> (acc_rdata == '0 ##1 claim_state == $past(claim_state))); // R10
   AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_hit |-> (acc_resp == 2'd0 && acc_rdata == '0 ##1 claim_state == $past(claim_state))); // R11
endmodule

bind dbg_claim_reg dbg_claim_sva #(.NUM_TAGS(NUM_TAGS), .DATA_W(DATA_W)) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_hit     (acc_hit),
   .acc_write   (acc_write),
   .acc_enc     (acc_enc),
   .acc_wdata   (acc_wdata),
   .cur_el      (cur_el),
   .has_a64     (has_a64),
   .acc_resp    (acc_resp),
   .acc_ec      (acc_ec),
   .acc_rdata   (acc_rdata),
   .claim_state (claim_state)
);

// File: tb/dbg_claim_reg_tb.sv
module dbg_claim_reg_tb;
   localparam logic [15:0] CLR = 16'h83CE;
   localparam logic [15:0] SET = 16'h83C6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 0, acc_write = 0;
   logic [15:0] acc_enc = '0;
   logic [63:0] acc_wdata = '0;
   logic [1:0]  cur_el = 2'd1;
   logic has_a64 = 1, el2_enabled = 0, has_el3 = 0, el3_undef_prio = 0, el3_sdd_undef = 0;
   logic el3_dbg_trap = 0, el2_dbg_route = 0, el2_dbg_trap = 0, fgt_impl = 0;
   logic el3_fgt_enable = 0, fgt_rd_claim = 0, fgt_wr_claim = 0;
   logic acc_hit;
   logic [1:0] acc_resp;
   logic [5:0] acc_ec;
   logic [63:0] acc_rdata;
   logic [7:0] claim_state;

   int n_cmp = 0, n_bad = 0;
   logic [7:0] model = '0;

   always #5 clk = ~clk;

   dbg_claim_reg u_dut (.*);

   function automatic logic [1:0] ref_outcome();
      logic fg;
      if (!has_a64 || cur_el == 0) return 2'd1;
      if (cur_el == 3) return 2'd0;
      if (has_el3 && el3_undef_prio && el3_dbg_trap) return 2'd1;
      fg = el2_enabled && fgt_impl && (!has_el3 || el3_fgt_enable) &&
           (acc_write ? fgt_wr_claim : fgt_rd_claim);
      if (cur_el == 1 && fg) return 2'd2;
      if (cur_el == 1 && el2_enabled && (el2_dbg_route || el2_dbg_trap)) return 2'd2;
      if (has_el3 && el3_dbg_trap) return el3_sdd_undef ? 2'd1 : 2'd3;
      return 2'd0;
   endfunction

   task automatic cmp(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // inputs are already set after a negedge; check, clock, check state
   task automatic step(input string req);
      logic hit;
      logic [1:0] o;
      #1;
      hit = acc_valid && (acc_enc == CLR || acc_enc == SET);
      o   = hit ? ref_outcome() : 2'd0;
      cmp(req, "hit", {63'd0, acc_hit}, {63'd0, hit});
      cmp(req, "resp", {62'd0, acc_resp}, {62'd0, o});
      cmp(req, "ec", {58'd0, acc_ec}, (o >= 2) ? 64'h18 : 64'h0);
      cmp(req, "rdata", acc_rdata, (hit && o == 0 && !acc_write) ? {56'd0, model} : 64'd0);
      if (hit && o == 0 && acc_write) begin
         if (acc_enc == CLR) model = model & ~acc_wdata[7:0];
         else                model = model | acc_wdata[7:0];
      end
      @(negedge clk);
      cmp(req, "state", {56'd0, claim_state}, {56'd0, model});
   endtask

   task automatic ctx_clear();
      cur_el = 1; has_a64 = 1; el2_enabled = 0; has_el3 = 0; el3_undef_prio = 0;
      el3_sdd_undef = 0; el3_dbg_trap = 0; el2_dbg_route = 0; el2_dbg_trap = 0;
      fgt_impl = 0; el3_fgt_enable = 0; fgt_rd_claim = 0; fgt_wr_claim = 0;
   endtask

   task automatic acc(input logic wr, input logic [15:0] enc, input logic [63:0] wd, input string req);
      acc_valid = 1; acc_write = wr; acc_enc = enc; acc_wdata = wd;
      step(req);
   endtask

   initial begin
      #200000;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      cmp("R1", "reset state", {56'd0, claim_state}, 64'd0);
      rst_n = 1;
      @(negedge clk);
      cmp("R1", "after release", {56'd0, claim_state}, 64'd0);

      // R4 set view, upper bits ignored; R2 reads via both views
      acc(1, SET, 64'hFFFF_FFFF_FFFF_FF5A, "R4");
      acc(0, CLR, 64'h0, "R2");
      acc(0, SET, 64'h0, "R2");
      // R3 clear view, zero bits unchanged
      acc(1, CLR, 64'hFF00_0000_0000_0012, "R3");
      acc(0, CLR, 64'h0, "R3");
      acc(1, SET, 64'h0, "R4");
      // R5 EL0 and missing feature
      cur_el = 0; acc(1, CLR, 64'hFF, "R5");
      cur_el = 2; has_a64 = 0; acc(0, SET, 64'h0, "R5");
      ctx_clear();
      // R6 priority: early undef beats fine-grained trap
      has_el3 = 1; el3_undef_prio = 1; el3_dbg_trap = 1; el2_enabled = 1;
      fgt_impl = 1; el3_fgt_enable = 1; fgt_wr_claim = 1;
      acc(1, CLR, 64'hFF, "R6");
      el3_undef_prio = 0; acc(1, CLR, 64'hFF, "R6");
      // R7 direction: read uses read bit (clear), so falls to EL3 trap
      acc(0, CLR, 64'h0, "R7");
      el3_fgt_enable = 0; acc(1, CLR, 64'hFF, "R7");
      el2_dbg_trap = 1; acc(1, CLR, 64'hFF, "R6");
      // R8 EL2 skips EL2 checks; EL3 always done
      cur_el = 2; acc(1, CLR, 64'hFF, "R8");
      el3_sdd_undef = 1; acc(0, CLR, 64'h0, "R8");
      cur_el = 3; acc(1, CLR, 64'h02, "R8");
      ctx_clear();
      // R11 miss and idle
      acc(1, 16'h83C7, 64'hFF, "R11");
      acc_valid = 0; acc_enc = SET; acc_write = 1; acc_wdata = 64'hFF; step("R11");

      for (int i = 0; i < 3000; i++) begin
         cur_el = 2'($urandom_range(0, 3));
         has_a64 = ($urandom_range(0, 15) != 0);
         el2_enabled = 1'($urandom_range(0, 1));
         has_el3 = 1'($urandom_range(0, 1));
         el3_undef_prio = ($urandom_range(0, 3) == 0);
         el3_sdd_undef = 1'($urandom_range(0, 1));
         el3_dbg_trap = ($urandom_range(0, 3) == 0);
         el2_dbg_route = ($urandom_range(0, 5) == 0);
         el2_dbg_trap = ($urandom_range(0, 5) == 0);
         fgt_impl = 1'($urandom_range(0, 1));
         el3_fgt_enable = 1'($urandom_range(0, 1));
         fgt_rd_claim = ($urandom_range(0, 3) == 0);
         fgt_wr_claim = ($urandom_range(0, 3) == 0);
         acc_valid = ($urandom_range(0, 7) != 0);
         acc_write = 1'($urandom_range(0, 1));
         case ($urandom_range(0, 4))
            0, 1:    acc_enc = CLR;
            2, 3:    acc_enc = SET;
            default: acc_enc = 16'($urandom);
         endcase
         acc_wdata = {$urandom, $urandom};
         step("R6");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule